// File: doc/BRIEF.md
# Mixed-Mode Interrupt Request Conditioner

This block sits between three asynchronous external interrupt request pins and the interrupt controller of a small processor. It brings each pin into the core clock domain and applies a separate trigger rule to each line. It then presents one pending flag per line to the controller. Line 0 is a plain level request. Line 1 fires on a low-to-high transition. Line 2 fires on the transition chosen by a polarity bit that software writes.

The level line is never stored: its flag tracks the synchronised pin while the global interrupt enable is high. The two edge lines hold a sticky flag once an accepted edge is seen. The core clears that flag with a one-cycle acknowledge on the matching bit. A change of the line 2 polarity bit could look like an edge, so the block masks edge detection on that line for the one clock after such a change.

Top module: `irq_trigger_unit`

## Requirements
- R1: `pend_o[0]` equals `irq_lvl_i` as sampled two rising clock edges earlier (two-flop synchroniser), ANDed with the present `int_en_i`. It is not latched, so it drops two edges after the pin falls.
- R2: A low-to-high transition on `irq_rise_i` sets `pend_o[1]` on the third rising edge after the pin changes. A high-to-low transition never sets it.
- R3: A one-cycle write (`pol_wr_i` high) loads `pol_d_i` into the line 2 polarity bit. With the bit at 1, a rising edge of `irq_sel_i` sets `pend_o[2]`; with the bit at 0, a falling edge sets it. In both cases the flag appears on the third edge after the pin changes, and the opposite edge does nothing.
- R4: An edge on line 1 or line 2 sets its flag only if `int_en_i` is high at the edge where the flag would be set. An edge seen while disabled is dropped and is not recovered when the enable returns.
- R5: `pend_o[1]` and `pend_o[2]` stay set until `ack_i[1]` or `ack_i[2]` respectively is high at a rising edge, which clears the flag at that edge. If a new accepted edge is seen at the same edge, the flag stays set.
- R6: `ack_i[0]` has no effect on any pending flag.
- R7: When a write changes the value of the polarity bit, edge detection on line 2 is masked for the following clock. The stored previous sample is kept, so the polarity change alone never sets `pend_o[2]`.
- R8: After reset all pending flags are 0 and the polarity bit is 0, so line 2 responds to falling edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_lvl_i | input | 1 | Line 0 request pin, level sensitive, active high, asynchronous |
| irq_rise_i | input | 1 | Line 1 request pin, rising-edge triggered, asynchronous |
| irq_sel_i | input | 1 | Line 2 request pin, edge selected by the polarity bit, asynchronous |
| int_en_i | input | 1 | Global interrupt enable |
| pol_wr_i | input | 1 | Write strobe for the line 2 polarity bit |
| pol_d_i | input | 1 | New polarity: 1 for rising, 0 for falling |
| ack_i | input | 3 | Acknowledge; bit n clears the flag of line n |
| pend_o | output | 3 | Pending flags; bit n belongs to line n |

## Verification
A wrong synchroniser depth or a missing previous-sample register shows at once as a pending flag one edge early or late, and the bench samples on both sides of the expected edge. A stale or badly reset previous sample on line 2 shows up as a flag raised with no pin activity, either just after reset or after a polarity write, within two clocks. A lost sticky bit or a wrong clear priority shows up at the first acknowledge that coincides with a new edge. Every such fault changes `pend_o` within three edges of its cause.

// File: rtl/irq_trig_pkg.sv
// Shared types for the interrupt request conditioner.
// Assumes a fixed assignment of trigger rules to line indices.
package irq_trig_pkg;

    typedef enum logic [1:0] {
        TRIG_LEVEL  = 2'd0,
        TRIG_RISE   = 2'd1,
        TRIG_SELECT = 2'd2
    } trig_mode_e;

    localparam int unsigned NUM_LINES = 3;

    // Trigger rule of each line index
    function automatic trig_mode_e line_mode(input int unsigned idx);
        case (idx)
            0:       return TRIG_LEVEL;
            1:       return TRIG_RISE;
            default: return TRIG_SELECT;
        endcase
    endfunction

endpackage

// File: rtl/irq_sync.sv
// Multi-stage flop synchroniser for a vector of asynchronous pins.
// Assumes each bit is independent; no bus coherency across bits.
module irq_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the pins through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/irq_pol_ctrl.sv
// Holds the line 2 edge polarity bit and flags a polarity change.
// Assumes the write strobe is one clock wide per write.
module irq_pol_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic d,
    output logic pol_q,
    output logic mask_q
);

    // Load the polarity bit; reset selects falling edges
    always_ff @(posedge clk) begin
        if (!rst_n)  pol_q <= 1'b0;
        else if (wr) pol_q <= d;
    end

    // Mask edge detection for one clock after a real change of polarity
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= 1'b0;
        else        mask_q <= wr && (d != pol_q);
    end

endmodule

// File: rtl/irq_line_detect.sv
// Trigger logic for one request line, variant chosen by MODE.
// Level mode: pending follows the synchronised sample gated by enable.
// Edge modes: the sample is made active-high via pol, compared with
// the stored previous value, and an accepted edge sets a sticky flag.
// Assumes smp is already synchronised; the previous-sample reset value
// matches a low pin with the polarity bit at its reset value.
module irq_line_detect
    import irq_trig_pkg::*;
#(
    parameter trig_mode_e MODE = TRIG_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp,
    input  logic pol,
    input  logic mask,
    input  logic en,
    input  logic ack,
    output logic pend,
    output logic set_o
);

    localparam logic PREV_RST = (MODE == TRIG_SELECT) ? 1'b1 : 1'b0;

    if (MODE == TRIG_LEVEL) begin : g_level
        logic unused_in;
        assign unused_in = ^{pol, mask, ack};
        assign pend  = smp & en;
        assign set_o = 1'b0;
    end else begin : g_edge
        logic adj;
        logic prev_q;
        logic pend_q;

        assign adj   = smp ^ ~pol;
        assign set_o = adj & ~prev_q & ~mask & en;
        assign pend  = pend_q;

        // Remember the polarity-adjusted sample of the previous clock
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= PREV_RST;
            else        prev_q <= adj;
        end

        // Sticky pending flag; a new edge wins over an acknowledge
        always_ff @(posedge clk) begin
            if (!rst_n)     pend_q <= 1'b0;
            else if (set_o) pend_q <= 1'b1;
            else if (ack)   pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_trigger_unit.sv
// Top of the interrupt request conditioner: synchronises three request
// pins and applies a level, rising-edge or selectable-edge rule per line.
// Assumes acknowledges come from the core in the same clock domain.
module irq_trigger_unit
    import irq_trig_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 irq_lvl_i,
    input  logic                 irq_rise_i,
    input  logic                 irq_sel_i,
    input  logic                 int_en_i,
    input  logic                 pol_wr_i,
    input  logic                 pol_d_i,
    input  logic [NUM_LINES-1:0] ack_i,
    output logic [NUM_LINES-1:0] pend_o
);

    logic [NUM_LINES-1:0] req_vec;
    logic [NUM_LINES-1:0] sync_vec;
    logic [NUM_LINES-1:0] set_vec;
    logic                 pol_q;
    logic                 sup_q;

    assign req_vec = {irq_sel_i, irq_rise_i, irq_lvl_i};

    irq_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (req_vec),
        .dout  (sync_vec)
    );

    irq_pol_ctrl u_pol (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (pol_wr_i),
        .d      (pol_d_i),
        .pol_q  (pol_q),
        .mask_q (sup_q)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam trig_mode_e M = line_mode(g);
        logic pol_l;
        logic mask_l;

        if (M == TRIG_SELECT) begin : g_sel
            assign pol_l  = pol_q;
            assign mask_l = sup_q;
        end else begin : g_fix
            assign pol_l  = 1'b1;
            assign mask_l = 1'b0;
        end

        irq_line_detect #(
            .MODE (M)
        ) u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .smp   (sync_vec[g]),
            .pol   (pol_l),
            .mask  (mask_l),
            .en    (int_en_i),
            .ack   (ack_i[g]),
            .pend  (pend_o[g]),
            .set_o (set_vec[g])
        );
    end

endmodule

// File: rtl/irq_trigger_unit_chk.sv
// Property checker for irq_trigger_unit, attached with bind below.
// Assumes the default two-stage synchroniser for the level latency check.
module irq_trigger_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] req_i,
    input logic       en_i,
    input logic [2:0] ack_i,
    input logic [2:0] pend_o,
    input logic [2:0] set_vec,
    input logic       sup_q
);

    logic [1:0] cyc_q;

    // Count clocks since reset, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)            cyc_q <= 2'd0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    p_level_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2) |-> (pend_o[0] == ($past(req_i[0], 2) & en_i)));

    p_no_start_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !pend_o[1]) |=> !pend_o[1]);

    p_no_start_disabled_l2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !pend_o[2]) |=> !pend_o[2]);

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o[1] && !ack_i[1]) |=> pend_o[1]);

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i[2] && !set_vec[2]) |=> !pend_o[2]);

    p_change_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_q && !pend_o[2]) |=> !pend_o[2]);

endmodule

bind irq_trigger_unit irq_trigger_unit_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   ({irq_sel_i, irq_rise_i, irq_lvl_i}),
    .en_i    (int_en_i),
    .ack_i   (ack_i),
    .pend_o  (pend_o),
    .set_vec (set_vec),
    .sup_q   (sup_q)
);

// File: tb/irq_trigger_unit_tb_top.sv
// Directed bench for irq_trigger_unit: one task per scenario.
module irq_trigger_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lvl = 1'b0, rise = 1'b0, sel = 1'b0, en = 1'b0;
    logic       wr = 1'b0, d = 1'b0;
    logic [2:0] ack = 3'b000;
    logic [2:0] pend;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    irq_trigger_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_lvl_i  (lvl),
        .irq_rise_i (rise),
        .irq_sel_i  (sel),
        .int_en_i   (en),
        .pol_wr_i   (wr),
        .pol_d_i    (d),
        .ack_i      (ack),
        .pend_o     (pend)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pend actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic ack_pulse(input int line);
        ack[line] = 1'b1;
        step(1);
        ack[line] = 1'b0;
    endtask

    task automatic write_pol(input logic v);
        wr = 1'b1; d = v;
        step(1);
        wr = 1'b0;
    endtask

    task automatic t_reset;
        step(3);
        chk("R8 reset flags", pend, 3'b000);
    endtask

    task automatic t_level;
        en = 1'b1;
        lvl = 1'b1;
        step(1);
        chk("R1 level one edge", pend, 3'b000);
        step(1);
        chk("R1 level two edges", pend, 3'b001);
        ack_pulse(0);
        chk("R6 ack0 ignored", pend, 3'b001);
        en = 1'b0; #1;
        chk("R1 level gated by enable", pend, 3'b000);
        @(negedge clk);
        en = 1'b1; #1;
        chk("R1 level enable back", pend, 3'b001);
        @(negedge clk);
        lvl = 1'b0;
        step(1);
        chk("R1 level still high", pend, 3'b001);
        step(1);
        chk("R1 level not latched", pend, 3'b000);
    endtask

    task automatic t_rise;
        rise = 1'b1;
        step(2);
        chk("R2 rise two edges", pend, 3'b000);
        step(1);
        chk("R2 rise three edges", pend, 3'b010);
        rise = 1'b0;
        step(4);
        chk("R5 sticky after fall", pend, 3'b010);
        ack_pulse(1);
        chk("R5 ack1 clears", pend, 3'b000);
        step(3);
        chk("R2 falling ignored", pend, 3'b000);
    endtask

    task automatic t_fall_default;
        sel = 1'b1;
        step(4);
        chk("R8 default ignores rise", pend, 3'b000);
        sel = 1'b0;
        step(2);
        chk("R3 fall two edges", pend, 3'b000);
        step(1);
        chk("R8 default falling sets", pend, 3'b100);
        ack_pulse(2);
        chk("R5 ack2 clears", pend, 3'b000);
    endtask

    task automatic t_select_rise;
        write_pol(1'b1);
        step(3);
        chk("R7 low pin no spurious", pend, 3'b000);
        sel = 1'b1;
        step(3);
        chk("R3 rising selected", pend, 3'b100);
        ack_pulse(2);
        sel = 1'b0;
        step(4);
        chk("R3 falling ignored when rising", pend, 3'b000);
    endtask

    task automatic t_suppress;
        write_pol(1'b0);
        step(3);
        chk("R7 polarity change masked", pend, 3'b000);
        sel = 1'b1;
        step(4);
        chk("R3 back to falling ignores rise", pend, 3'b000);
        sel = 1'b0;
        step(3);
        chk("R3 back to falling sets", pend, 3'b100);
        ack_pulse(2);
    endtask

    task automatic t_enable_gate;
        en = 1'b0;
        rise = 1'b1;
        step(4);
        chk("R4 edge while disabled", pend, 3'b000);
        en = 1'b1;
        step(3);
        chk("R4 dropped edge not recovered", pend, 3'b000);
        rise = 1'b0;
        step(3);
        rise = 1'b1;
        step(3);
        chk("R4 edge while enabled", pend, 3'b010);
        ack_pulse(1);
        rise = 1'b0;
        step(3);
    endtask

    task automatic t_collide;
        rise = 1'b1;
        step(3);
        rise = 1'b0;
        step(3);
        chk("R5 pending before collide", pend, 3'b010);
        rise = 1'b1;
        step(2);
        ack[1] = 1'b1;
        step(1);
        ack[1] = 1'b0;
        chk("R5 new edge beats ack", pend, 3'b010);
        ack_pulse(1);
        chk("R5 later ack clears", pend, 3'b000);
        rise = 1'b0;
        step(3);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        t_reset();
        t_level();
        t_rise();
        t_fall_default();
        t_select_rise();
        t_suppress();
        t_enable_gate();
        t_collide();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule